// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects a vector of interrupt sources and turns them into a grid of interrupt lines, one for each pairing of processor core and parent interrupt input. Each source can be sensed as a level (active high or active low) or as an edge (rising or falling). An edge is caught in a sticky pending bit. Each source is gated by its bit in an enable state. A route byte then steers it to one parent line on one core.

Software reaches the block through a single-cycle register port. A write strobe is qualified by a width select: byte or word. Writes take effect at the next clock edge, and read data follows the address combinationally. The enable state is written through two registers: one sets bits by writing ones, the other clears bits by writing ones. This lets software unmask or mask any group of sources without a read-modify-write.

The output grid is combinational from the block's registers. A sampled level therefore reaches the lines one edge after it appears at the input. A detected edge reaches them two edges after it appears.

Top module: `irq_route_hub`

## Requirements
- R1: The route byte of source n sits at byte address n (0x00 to 0x1F). A byte write (`bus_word`=0) stores `bus_wdata[7:0]` into that one byte. A word write to address 4k stores `bus_wdata` into the route bytes of sources 4k..4k+3, with the lowest byte going to the lowest source. A read in this range returns the aligned word, packed the same way.
- R2: A word write to 0x28 sets every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R3: A word write to 0x2C clears every enable bit whose data bit is 1 and leaves the other enable bits unchanged. Writing 0xFFFFFFFF there masks all sources and drops every output line.
- R4: Reading 0x24 returns the enable state. The registers at 0x24 and above (0x24, 0x28, 0x2C, 0x30, 0x34, 0x40) ignore byte writes.
- R5: A source whose bit in the edge register (0x34) is 0 is level sensed. Its polarity bit (0x30) chooses the active level: 1 for high, 0 for low. Its pending value follows the input one clock edge after the input changes.
- R6: A source whose edge bit is 1 is edge sensed. Polarity 1 selects the rising edge and polarity 0 the falling edge. The selected edge sets a sticky pending bit, visible two clock edges after the input change. The bit stays set after the input returns, and the opposite edge does not set it.
- R7: Writing a 1 for a source to either the set register (0x28) or the clear register (0x2C) clears that source's sticky pending bit.
- R8: Reading 0x40 returns the pending bits ANDed with the enable state.
- R9: Output `irq_o[c*4+p]` is high when at least one source is pending, enabled, and has both core bit c (route bit c) and parent bit p (route bit 4+p) set.
- R10: A source whose route byte has an empty core nibble or an empty parent nibble drives no output line, even when it is pending and enabled.
- R11: After reset, all enable bits, route bytes, edge bits, sticky bits and output lines are 0, and the polarity register reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt source inputs |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_word | input | 1 | 1 = word write, 0 = byte write |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 16 | Output lines, index core*4+parent |

## Verification
Register writes become visible after one rising edge, so the bench drives each write at a falling edge and reads back at the next falling edge. A level on `src_i` appears on `irq_o` and in the status register after one rising edge. A sensed edge needs two rising edges: one to sample the input and one to set the sticky bit. The bench waits exactly those counts before it samples, and in the edge case it also checks after a single edge that the bit has not yet appeared. All samples are taken midway between rising edges, where nothing is changing.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned SRC_COUNT  = 32;
    localparam int unsigned PAR_COUNT  = 4;
    localparam int unsigned CORE_COUNT = 4;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LANES      = DATA_W / 8;

    // Register offsets that software depends on
    localparam logic [ADDR_W-1:0] OFS_EN_STATE = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_POL      = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_EDGE     = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h40;

    // One route byte: parent nibble high, core nibble low
    typedef struct packed {
        logic [3:0] par;
        logic [3:0] core;
    } route_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'b00,
        WR_BYTE = 2'b01,
        WR_WORD = 2'b10
    } wr_kind_e;

    function automatic wr_kind_e decode_wr(input logic we, input logic word);
        if (!we)  return WR_NONE;
        if (word) return WR_WORD;
        return WR_BYTE;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic                      word,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [NSRC-1:0]           status_i,
    output route_t [NSRC-1:0]         route_o,
    output logic [NSRC-1:0]           en_o,
    output logic [NSRC-1:0]           pol_o,
    output logic [NSRC-1:0]           edge_o,
    output logic [NSRC-1:0]           ack_o
);

    localparam int unsigned GROUPS = NSRC / LANES;

    wr_kind_e          kind;
    logic              in_route;
    route_t [NSRC-1:0] route_q;
    logic [NSRC*8-1:0] route_flat;
    logic [NSRC-1:0]   en_q, pol_q, edge_q;
    logic              wr_set, wr_clr;

    assign kind     = decode_wr(we, word);
    assign in_route = (addr < ADDR_W'(NSRC));
    assign wr_set   = (kind == WR_WORD) && (addr == OFS_EN_SET);
    assign wr_clr   = (kind == WR_WORD) && (addr == OFS_EN_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (kind == WR_BYTE && addr == ADDR_W'(i))
                    route_q[i] <= route_t'(wdata[7:0]);
                else if (kind == WR_WORD && in_route &&
                         addr[ADDR_W-1:2] == (ADDR_W-2)'(i / LANES))
                    route_q[i] <= route_t'(wdata[8*(i % LANES) +: 8]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '1;
            edge_q <= '0;
        end else begin
            if (wr_set)
                en_q <= en_q | wdata[NSRC-1:0];
            else if (wr_clr)
                en_q <= en_q & ~wdata[NSRC-1:0];
            if (kind == WR_WORD && addr == OFS_POL)
                pol_q <= wdata[NSRC-1:0];
            if (kind == WR_WORD && addr == OFS_EDGE)
                edge_q <= wdata[NSRC-1:0];
        end
    end

    assign route_flat = route_q;
    assign ack_o      = (wr_set || wr_clr) ? wdata[NSRC-1:0] : '0;
    assign route_o    = route_q;
    assign en_o       = en_q;
    assign pol_o      = pol_q;
    assign edge_o     = edge_q;

    always_comb begin
        rdata = '0;
        if (in_route) begin
            for (int g = 0; g < GROUPS; g++)
                if (addr[ADDR_W-1:2] == (ADDR_W-2)'(g))
                    rdata = route_flat[g*DATA_W +: DATA_W];
        end else begin
            case (addr)
                OFS_EN_STATE: rdata = DATA_W'(en_q);
                OFS_POL:      rdata = DATA_W'(pol_q);
                OFS_EDGE:     rdata = DATA_W'(edge_q);
                OFS_STATUS:   rdata = DATA_W'(status_i);
                default:      rdata = '0;
            endcase
        end
    end

    p_route_byte_r1: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_BYTE && in_route) |=>
            (route_flat[$past(addr)*8 +: 8] == $past(wdata[7:0])));

    p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((en_q & $past(wdata[NSRC-1:0])) == '0));

    p_byte_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_BYTE && !in_route) |=> ($stable(en_q) && $stable(pol_q) && $stable(edge_q)));

endmodule

// File: rtl/irq_route_sense.sv
module irq_route_sense
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] pol_i,
    input  logic [NSRC-1:0] edge_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] pend_o
);

    logic [NSRC-1:0] in_q, prev_q, latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= '0;
            prev_q <= '0;
        end else begin
            in_q   <= src_i;
            prev_q <= in_q;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        logic rise, fall, hit;

        assign rise = in_q[i] & ~prev_q[i];
        assign fall = ~in_q[i] & prev_q[i];
        assign hit  = pol_i[i] ? rise : fall;

        always_ff @(posedge clk) begin
            if (rst || !edge_i[i])
                latch_q[i] <= 1'b0;
            else
                latch_q[i] <= (latch_q[i] & ~ack_i[i]) | hit;
        end

        assign pend_o[i] = edge_i[i] ? latch_q[i] : ~(in_q[i] ^ pol_i[i]);

        p_latch_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (edge_i[i] && latch_q[i] && !ack_i[i]) |=> latch_q[i]);

        p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
            (edge_i[i] && ack_i[i] && !hit) |=> !latch_q[i]);

        p_level_tracks_r5: assert property (@(posedge clk) disable iff (rst)
            !edge_i[i] |=> (edge_i[i] || pend_o[i] == ($past(src_i[i]) ~^ pol_i[i])));
    end

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC  = SRC_COUNT,
    parameter int unsigned NPAR  = PAR_COUNT,
    parameter int unsigned NCORE = CORE_COUNT
) (
    input  logic [NSRC-1:0]        act_i,
    input  route_t [NSRC-1:0]      route_i,
    output logic [NCORE*NPAR-1:0]  line_o
);

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar p = 0; p < NPAR; p++) begin : g_par
            logic [NSRC-1:0] sel;
            for (genvar i = 0; i < NSRC; i++) begin : g_src
                assign sel[i] = route_i[i].core[c] & route_i[i].par[p];
            end
            assign line_o[c*NPAR + p] = |(sel & act_i);
        end
    end

endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC  = SRC_COUNT,
    parameter int unsigned NPAR  = PAR_COUNT,
    parameter int unsigned NCORE = CORE_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          src_i,
    input  logic                     bus_we,
    input  logic                     bus_word,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NCORE*NPAR-1:0]    irq_o
);

    route_t [NSRC-1:0] route;
    logic [NSRC-1:0]   en, pol, edge_sel, ack, pend, status;

    irq_route_regs #(.NSRC(NSRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .word     (bus_word),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .status_i (status),
        .route_o  (route),
        .en_o     (en),
        .pol_o    (pol),
        .edge_o   (edge_sel),
        .ack_o    (ack)
    );

    irq_route_sense #(.NSRC(NSRC)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .pol_i  (pol),
        .edge_i (edge_sel),
        .ack_i  (ack),
        .pend_o (pend)
    );

    assign status = pend & en;

    irq_route_xbar #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_xbar (
        .act_i   (status),
        .route_i (route),
        .line_o  (irq_o)
    );

    p_line_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        (|irq_o) |-> (|en));

    p_mask_all_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_word && bus_addr == OFS_EN_CLR && bus_wdata == '1) |=> (irq_o == '0));

endmodule

// File: tb/irq_route_hub_tb_top.sv
module irq_route_hub_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        we = 1'b0, word = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_hub dut_i (
        .clk(clk), .rst(rst), .src_i(src),
        .bus_we(we), .bus_word(word), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    // {source pattern, expected lines}, all sources enabled, level active-high
    localparam logic [47:0] VECS [0:7] = '{
        {32'h0000_0001, 16'h0001},   // src0: core0 parent0
        {32'h0000_0010, 16'h0002},   // src4: core0 parent1
        {32'h0000_0020, 16'h0020},   // src5: core1 parent1
        {32'h0000_0040, 16'h0200},   // src6: core2 parent1
        {32'h0000_2000, 16'h0080},   // src13: core1 parent3
        {32'hFFFF_0000, 16'h0000},   // unrouted half (R10)
        {32'h0000_FFFF, 16'hFFFF},   // every routed source
        {32'h0000_0000, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        we = 1'b1; word = w; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; word = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        rd(8'h24, v); check("R11 enable", v, 32'h0);
        rd(8'h00, v); check("R11 route lo", v, 32'h0);
        rd(8'h1C, v); check("R11 route hi", v, 32'h0);
        rd(8'h30, v); check("R11 polarity", v, 32'hFFFF_FFFF);
        rd(8'h34, v); check("R11 edge", v, 32'h0);
        rd(8'h40, v); check("R11 status", v, 32'h0);
        check("R11 lines", {16'h0, irq}, 32'h0);

        // R1 byte and word access to route bytes
        wr(8'h05, 32'h1234_56AB, 1'b0);
        rd(8'h04, v); check("R1 byte lane", v, 32'h0000_AB00);
        wr(8'h04, 32'h1122_3344, 1'b1);
        rd(8'h04, v); check("R1 word", v, 32'h1122_3344);

        // R4 byte write above the route range is ignored
        wr(8'h30, 32'h0000_0000, 1'b0);
        rd(8'h30, v); check("R4 byte ignored", v, 32'hFFFF_FFFF);

        // routing: source i -> core i[1:0], parent i[3:2]
        wr(8'h00, 32'h1814_1211, 1'b1);
        wr(8'h04, 32'h2824_2221, 1'b1);
        wr(8'h08, 32'h4844_4241, 1'b1);
        wr(8'h0C, 32'h8884_8281, 1'b1);
        wr(8'h10, 32'h1010_1010, 1'b1);
        wr(8'h14, 32'h1010_1010, 1'b1);
        wr(8'h18, 32'h0101_0101, 1'b1);
        wr(8'h1C, 32'h0101_0101, 1'b1);
        rd(8'h0C, v); check("R1 readback", v, 32'h8884_8281);

        // R2 enable set
        wr(8'h28, 32'hFFFF_FFFF, 1'b1);
        rd(8'h24, v); check("R2 enable all", v, 32'hFFFF_FFFF);

        // R9 / R10 / R8 table walk
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            src = VECS[k][47:16];
            tick(1);
            check($sformatf("R9 vec%0d lines", k), {16'h0, irq}, {16'h0, VECS[k][15:0]});
            rd(8'h40, v);
            check($sformatf("R8 vec%0d status", k), v, VECS[k][47:16]);
        end

        // R3 partial clear, R8 masking
        wr(8'h2C, 32'h0000_FFFE, 1'b1);
        rd(8'h24, v); check("R3 partial clear", v, 32'hFFFF_0001);
        src = 32'h0000_FFFF;
        tick(1);
        check("R9 masked lines", {16'h0, irq}, 32'h0000_0001);
        rd(8'h40, v); check("R8 masked status", v, 32'h0000_0001);

        // R3 mask all
        wr(8'h2C, 32'hFFFF_FFFF, 1'b1);
        rd(8'h24, v); check("R3 enable cleared", v, 32'h0);
        check("R3 lines dropped", {16'h0, irq}, 32'h0);

        // R5 active-low level on source 0
        src = '0;
        wr(8'h28, 32'h0000_0001, 1'b1);
        wr(8'h30, 32'hFFFF_FFFE, 1'b1);
        tick(1);
        check("R5 low active", {16'h0, irq}, 32'h0000_0001);
        src = 32'h1;
        tick(1);
        check("R5 high inactive", {16'h0, irq}, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF, 1'b1);
        src = '0;
        tick(1);
        check("R5 high idle", {16'h0, irq}, 32'h0);

        // R6 rising edge on source 1 (core1 parent0 -> line 4)
        wr(8'h34, 32'h0000_0002, 1'b1);
        wr(8'h28, 32'h0000_0002, 1'b1);
        src = 32'h2;
        tick(1);
        rd(8'h40, v); check("R6 not yet", v, 32'h0);
        tick(1);
        rd(8'h40, v); check("R6 rise caught", v, 32'h2);
        src = '0;
        tick(2);
        rd(8'h40, v); check("R6 sticky", v, 32'h2);
        check("R6 line", {16'h0, irq}, 32'h0000_0010);

        // R7 clear via disable, then re-enable leaves it clear
        wr(8'h2C, 32'h0000_0002, 1'b1);
        wr(8'h28, 32'h0000_0002, 1'b1);
        rd(8'h40, v); check("R7 disable clears", v, 32'h0);

        // R6 falling edge select
        wr(8'h30, 32'hFFFF_FFFD, 1'b1);
        src = 32'h2;
        tick(2);
        rd(8'h40, v); check("R6 rise ignored", v, 32'h0);
        src = '0;
        tick(2);
        rd(8'h40, v); check("R6 fall caught", v, 32'h2);

        // R7 clear via enable write
        wr(8'h28, 32'h0000_0002, 1'b1);
        rd(8'h40, v); check("R7 enable clears", v, 32'h0);
        check("R7 line low", {16'h0, irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule